// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator (Dual Channel)

This block is a clocked model of a retriggerable monostable. Each channel watches three asynchronous control pins: an active-low trigger, an active-high trigger and an active-low clear. A qualifying edge on any of them starts an output pulse whose length, in system clock cycles, comes from a per-channel width input. The output pair is a true output and its complement. A qualifying edge that arrives while a pulse is running restarts the count, so the pulse ends one full width after the most recent trigger. Pulling clear low stops the pulse at once and holds the output low until clear is released.

Each channel is a small state machine with three named states. OS_IDLE is standby with the output low. OS_PULSE is the timed pulse with the output high. OS_HOLD means clear is held low. The transitions are:
- START: OS_IDLE to OS_PULSE, on a qualifying edge with a non-zero width.
- RETRIG: OS_PULSE to OS_PULSE, on a qualifying edge, which reloads the count.
- EXPIRE: OS_PULSE to OS_IDLE, when the last counted cycle passes.
- CLEAR: any state to OS_HOLD, while clear is low.
- RELEASE: OS_HOLD to OS_IDLE, when clear goes high with no qualifying edge.
- RELEASE_START: OS_HOLD to OS_PULSE, when the release of clear is itself a qualifying edge.

Each pin passes through a two-flop synchronizer. An edge is found by comparing the synchronized value with its value one cycle earlier. The two channels share only the clock and the reset.

Top module: `dual_oneshot`

## Requirements
- R1: While reset is high, and after it is released with the pins at rest (trig_a_n high, trig_b low, clr_n high), every channel is in standby: `q` is 0 and `q_n` is 1.
- R2: In every cycle after reset, `q_n` is the inverse of `q` on every channel.
- R3: A falling edge on `trig_a_n` while `trig_b` is high and `clr_n` is high starts a pulse. Counted from the rising clock edge that first samples the new pin level, `q` rises on the third rising edge and stays high for exactly `pulse_len` cycles.
- R4: A rising edge on `trig_b` while `trig_a_n` is low and `clr_n` is high starts a pulse, with the same latency and length as R3.
- R5: A rising edge on `clr_n` while `trig_a_n` is low and `trig_b` is high starts a pulse, with the same latency and length as R3.
- R6: While the synchronized `clr_n` is low, `q` is 0, whatever the triggers do. A pulse in progress ends on the third rising edge after clear falls. When a trigger edge and a low clear occur in the same cycle, the clear wins.
- R7: A qualifying edge during a pulse reloads the count, so `q` stays high until `pulse_len` cycles after that latest trigger.
- R8: Edges that do not qualify leave the outputs unchanged. Examples are a rising edge on `trig_b` with `trig_a_n` high, a falling edge on `trig_b`, and a falling edge on `trig_a_n` with `trig_b` low.
- R9: A qualifying edge while `pulse_len` is 0 has no effect. It starts no pulse and does not shorten or restart one that is running.
- R10: The channels are independent. Activity on one channel's pins never changes the other channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_a_n | input | CHANNELS | Per-channel active-low trigger (falling edge) |
| trig_b | input | CHANNELS | Per-channel active-high trigger (rising edge) |
| clr_n | input | CHANNELS | Per-channel active-low clear; its rising edge is also a trigger |
| pulse_len | input | CHANNELS x WIDTH_BITS | Per-channel pulse length in clock cycles |
| q | output | CHANNELS | Pulse output |
| q_n | output | CHANNELS | Complement of `q` |

## Verification
The pins are driven in several patterns:
- Each single trigger path on its own. These show that each edge type and its qualifying levels are decoded separately.
- Edges with the wrong polarity, or with the other pins at disqualifying levels. These separate a true qualifying edge from a mere change of level.
- Retriggers in mid-pulse, clears in mid-pulse, and a trigger that coincides with a low clear. These separate restart from ignore and show the clear priority.
- Zero-width triggers, both from standby and during a pulse.
- Overlapping activity on both channels, which exposes any coupling between them.

A behavioural model in the bench predicts `q` on every clock for both channels.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    typedef enum logic [1:0] {
        OS_IDLE  = 2'd0,
        OS_PULSE = 2'd1,
        OS_HOLD  = 2'd2
    } os_state_e;

    typedef struct packed {
        logic a_n;
        logic b;
        logic clr_n;
    } os_pins_t;

    localparam os_pins_t OS_PINS_REST = '{a_n: 1'b1, b: 1'b0, clr_n: 1'b1};

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync
    import oneshot_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  os_pins_t pins_raw,
    output os_pins_t pins_sync
);

    os_pins_t chain [STAGES];

    generate
        for (genvar st = 0; st < STAGES; st++) begin : g_stage
            if (st == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[st] <= OS_PINS_REST;
                    else     chain[st] <= pins_raw;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain[st] <= OS_PINS_REST;
                    else     chain[st] <= chain[st-1];
                end
            end
        end
    endgenerate

    assign pins_sync = chain[STAGES-1];

endmodule

// File: rtl/oneshot_trig.sv
module oneshot_trig
    import oneshot_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  os_pins_t pins_now,
    output logic     fire,
    output logic     clr_low
);

    os_pins_t pins_prev;
    logic     edge_a, edge_b, edge_c;

    always_ff @(posedge clk) begin
        if (rst) pins_prev <= OS_PINS_REST;
        else     pins_prev <= pins_now;
    end

    always_comb begin
        edge_a  = pins_prev.a_n & ~pins_now.a_n & pins_now.b & pins_now.clr_n;
        edge_b  = ~pins_prev.b & pins_now.b & ~pins_now.a_n & pins_now.clr_n;
        edge_c  = ~pins_prev.clr_n & pins_now.clr_n & ~pins_now.a_n & pins_now.b;
        fire    = edge_a | edge_b | edge_c;
        clr_low = ~pins_now.clr_n;
    end

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
    import oneshot_pkg::*;
#(
    parameter int WIDTH_BITS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  fire,
    input  logic                  clr_low,
    input  logic [WIDTH_BITS-1:0] width,
    output logic                  q,
    output logic                  q_n
);

    localparam logic [WIDTH_BITS-1:0] CNT_ONE = WIDTH_BITS'(1);

    os_state_e             state, nxt;
    logic [WIDTH_BITS-1:0] cnt, cnt_nxt;
    logic                  load;

    assign load = fire && (width != '0);

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        unique case (state)
            OS_IDLE: begin
                if (clr_low) begin
                    nxt = OS_HOLD;                 // CLEAR
                end else if (load) begin
                    nxt     = OS_PULSE;            // START
                    cnt_nxt = width;
                end
            end
            OS_PULSE: begin
                if (clr_low) begin
                    nxt     = OS_HOLD;             // CLEAR
                    cnt_nxt = '0;
                end else if (load) begin
                    cnt_nxt = width;               // RETRIG
                end else if (cnt == CNT_ONE) begin
                    nxt     = OS_IDLE;             // EXPIRE
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt - CNT_ONE;
                end
            end
            OS_HOLD: begin
                if (!clr_low) begin
                    if (load) begin
                        nxt     = OS_PULSE;        // RELEASE_START
                        cnt_nxt = width;
                    end else begin
                        nxt = OS_IDLE;             // RELEASE
                    end
                end
            end
            default: begin
                nxt     = OS_IDLE;
                cnt_nxt = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= OS_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= 1'b0;
            q_n <= 1'b1;
        end else begin
            q   <= (nxt == OS_PULSE);
            q_n <= (nxt != OS_PULSE);
        end
    end

    a_r2_complement: assert property (@(posedge clk) disable iff (rst)
        q != q_n);

    a_r6_clear_forces_low: assert property (@(posedge clk) disable iff (rst)
        clr_low |=> (!q && q_n));

    a_r3_fire_loads_width: assert property (@(posedge clk) disable iff (rst)
        (fire && !clr_low && width != '0) |=> (q && cnt == $past(width)));

    a_r9_zero_width_no_start: assert property (@(posedge clk) disable iff (rst)
        (fire && width == '0 && !q) |=> !q);

    a_r7_active_count_nonzero: assert property (@(posedge clk) disable iff (rst)
        q |-> (cnt != '0));

endmodule

// File: rtl/dual_oneshot.sv
module dual_oneshot
    import oneshot_pkg::*;
#(
    parameter int CHANNELS    = 2,
    parameter int WIDTH_BITS  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [CHANNELS-1:0]                  trig_a_n,
    input  logic [CHANNELS-1:0]                  trig_b,
    input  logic [CHANNELS-1:0]                  clr_n,
    input  logic [CHANNELS-1:0][WIDTH_BITS-1:0]  pulse_len,
    output logic [CHANNELS-1:0]                  q,
    output logic [CHANNELS-1:0]                  q_n
);

    generate
        for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
            os_pins_t raw_pins, sync_pins;
            logic     fire, clr_low;

            assign raw_pins = '{a_n: trig_a_n[ch], b: trig_b[ch], clr_n: clr_n[ch]};

            oneshot_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk       (clk),
                .rst       (rst),
                .pins_raw  (raw_pins),
                .pins_sync (sync_pins)
            );

            oneshot_trig u_trig (
                .clk      (clk),
                .rst      (rst),
                .pins_now (sync_pins),
                .fire     (fire),
                .clr_low  (clr_low)
            );

            oneshot_timer #(.WIDTH_BITS(WIDTH_BITS)) u_timer (
                .clk     (clk),
                .rst     (rst),
                .fire    (fire),
                .clr_low (clr_low),
                .width   (pulse_len[ch]),
                .q       (q[ch]),
                .q_n     (q_n[ch])
            );
        end
    endgenerate

endmodule

// File: tb/dual_oneshot_test.sv
`timescale 1ns/1ps
module dual_oneshot_test;

    localparam int NCH = 2;
    localparam int WB  = 8;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic [NCH-1:0]           trig_a_n = '1;
    logic [NCH-1:0]           trig_b   = '0;
    logic [NCH-1:0]           clr_n    = '1;
    logic [NCH-1:0][WB-1:0]   pulse_len;
    logic [NCH-1:0]           q, q_n;

    int    checks   = 0;
    int    failures = 0;
    string cur_req  = "R1";

    // model state: bit 2 = a_n, bit 1 = b, bit 0 = clr_n
    logic [2:0] m_d1 [NCH];
    logic [2:0] m_d2 [NCH];
    logic [2:0] m_pv [NCH];
    int         remain [NCH];

    always #5 clk = ~clk;

    dual_oneshot #(.CHANNELS(NCH), .WIDTH_BITS(WB), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .trig_a_n(trig_a_n), .trig_b(trig_b),
        .clr_n(clr_n), .pulse_len(pulse_len), .q(q), .q_n(q_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    // behavioural reference, updated on every rising edge
    always @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            logic [2:0] s, p;
            bit hit;
            if (rst) begin
                m_d1[c] = 3'b101; m_d2[c] = 3'b101; m_pv[c] = 3'b101; remain[c] = 0;
            end else begin
                s = m_d2[c];
                p = m_pv[c];
                hit = (p[2] && !s[2] && s[1] && s[0])
                   || (!p[1] && s[1] && !s[2] && s[0])
                   || (!p[0] && s[0] && !s[2] && s[1]);
                if (!s[0])                              remain[c] = 0;
                else if (hit && pulse_len[c] != 0)      remain[c] = int'(pulse_len[c]);
                else if (remain[c] > 0)                 remain[c] = remain[c] - 1;
                m_pv[c] = s;
                m_d2[c] = m_d1[c];
                m_d1[c] = {trig_a_n[c], trig_b[c], clr_n[c]};
            end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (!rst) begin
            for (int c = 0; c < NCH; c++) begin
                chk(q[c] == (remain[c] > 0), cur_req, int'(q[c]), int'(remain[c] > 0));
                chk(q_n[c] == ~q[c], "R2", int'(q_n[c]), int'(~q[c]));
            end
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        pulse_len[0] = 8'd5;
        pulse_len[1] = 8'd3;
        cyc(4);
        chk(q == '0, "R1", int'(q), 0);
        chk(q_n == '1, "R1", int'(q_n), 3);
        rst = 1'b0;
        cyc(3);
        chk(q == '0, "R1", int'(q), 0);

        // R8: b rises while a is high on both channels
        cur_req = "R8";
        trig_b = 2'b11; cyc(8);
        // R3: a falls with b high
        cur_req = "R3";
        trig_a_n[0] = 1'b0; cyc(12);
        // R8: b falls (no effect); R4: b rises with a low
        cur_req = "R8";
        trig_b[0] = 1'b0; cyc(5);
        cur_req = "R4";
        trig_b[0] = 1'b1; cyc(10);
        // R5: clear low then released with a low, b high
        cur_req = "R5";
        clr_n[0] = 1'b0; cyc(5);
        clr_n[0] = 1'b1; cyc(10);
        // R7: retrigger in mid-pulse
        cur_req = "R7";
        trig_b[0] = 1'b0; cyc(1); trig_b[0] = 1'b1; cyc(4);
        trig_b[0] = 1'b0; cyc(1); trig_b[0] = 1'b1; cyc(12);
        // R6: clear mid-pulse; then trigger and clear in the same cycle
        cur_req = "R6";
        trig_b[0] = 1'b0; cyc(1); trig_b[0] = 1'b1; cyc(4);
        clr_n[0] = 1'b0; cyc(6);
        clr_n[0] = 1'b1; cyc(10);
        trig_b[0] = 1'b0; cyc(3);
        trig_b[0] = 1'b1; clr_n[0] = 1'b0; cyc(6);
        clr_n[0] = 1'b1; cyc(10);
        // R9: zero width from standby, then during a pulse
        cur_req = "R9";
        pulse_len[0] = 8'd0;
        trig_b[0] = 1'b0; cyc(2); trig_b[0] = 1'b1; cyc(8);
        pulse_len[0] = 8'd6;
        trig_b[0] = 1'b0; cyc(2); trig_b[0] = 1'b1; cyc(4);
        pulse_len[0] = 8'd0;
        trig_b[0] = 1'b0; cyc(1); trig_b[0] = 1'b1; cyc(10);
        // R8: a falls while b is low (channel 0)
        cur_req = "R8";
        trig_a_n[0] = 1'b1; trig_b[0] = 1'b0; pulse_len[0] = 8'd4; cyc(4);
        trig_a_n[0] = 1'b0; cyc(8);
        // R10: overlapping activity on both channels
        cur_req = "R10";
        trig_b[0] = 1'b1; cyc(1);
        trig_a_n[1] = 1'b0; cyc(2);
        clr_n[1] = 1'b0; cyc(3);
        clr_n[1] = 1'b1; pulse_len[0] = 8'd7; cyc(1);
        trig_b[0] = 1'b0; cyc(1); trig_b[0] = 1'b1; cyc(15);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule